// File: doc/BRIEF.md
# DRAM-Backed Monochrome LCD Scan Controller

This block repaints a passive monochrome LCD panel from an image held in an external 4-bit-wide DRAM. The panel is 320 × 240 pixels by default. Each pixel is one bit, so a 4-bit memory word holds four adjacent pixels of a line. The controller reads the image continuously in raster order. It shifts each word onto a 4-bit panel data output and gives one pixel-clock pulse per word. It also marks line ends and frame starts. Every full pass over the image touches every DRAM row, so the scan itself keeps the memory refreshed. No separate refresh sequencer exists.

The DRAM has no dedicated data lines. One 8-bit bidirectional bus carries three things in turn: the row address, which the memory latches when RAS falls; the column address, which it latches when CAS falls; and then the data word in the low four bits. The block runs one memory access per time slot of fixed length. Each slot holds one scan read, followed by a window that holds at most one host write. A host can store one byte at a time through a valid/ready port. The byte becomes two nibble writes: the high nibble goes to the even nibble address and the low nibble to the odd one. The write traffic never changes the pixel rate seen by the panel.

Top module: `lcdscan_top`

## Requirements
- R1: While reset is high, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are all 1. `lcd_xscl`, `lcd_lp`, `lcd_flm` and `lcd_tgl` are all 0, and `host_ready` is 1.
- R2: Scan read k of a frame uses nibble address k, counting from 0. The bus carries address bits [7:0] when RAS falls and address bits [15:8] when CAS falls. Consecutive scan reads therefore step through the DRAM rows.
- R3: OE goes low only while RAS and CAS are both low, and the block releases the bus before OE falls. At the end of a read, OE rises first, then CAS, then RAS.
- R4: The nibble read while OE is low appears on `lcd_data` before a one-cycle `lcd_xscl` pulse. Pixel words reach the panel in scan-address order.
- R5: The time between two `lcd_xscl` pulses is always 19 clock cycles, whether host writes are pending or not.
- R6: `lcd_lp` is a one-cycle pulse that follows every H_PIX/4-th `lcd_xscl` pulse, and no others.
- R7: `lcd_flm` is high only together with `lcd_lp`. It is high on the line-end pulse of line 0 of each frame, which is once every V_LINES line pulses.
- R8: `lcd_tgl` inverts in the cycle after each `lcd_flm` pulse and holds its value at all other times.
- R9: A byte is accepted on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is 0 in the following cycle and returns to 1 once both nibbles are written. Bits [7:4] go to nibble address 2·`host_addr` and bits [3:0] go to nibble address 2·`host_addr`+1.
- R10: WE goes low only while RAS and CAS are low and OE is high. During that time the bus carries the data nibble in bits [3:0], with bits [7:4] at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host offers a byte |
| host_ready | output | 1 | Block can accept a byte |
| host_addr | input | 15 | Byte address (nibble address / 2) |
| host_data | input | 8 | Byte to store |
| dram_ad | inout | 8 | Shared row/column/data bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| lcd_data | output | 4 | Four pixels for the panel |
| lcd_xscl | output | 1 | Pixel-word clock pulse |
| lcd_lp | output | 1 | Line-end pulse |
| lcd_flm | output | 1 | Frame-start marker |
| lcd_tgl | output | 1 | Level that inverts once per frame |

## Verification
The first frame is scanned from a memory that has never been written. This checks that every pixel word comes out as zero and shows where each scan read lands. Next, two different byte patterns are written, and each is compared with the following whole frame. This separates a correct nibble order within each byte from a swapped one, and a correct address order from a shifted or reversed one. A later single-byte overwrite must change exactly two pixel words. The pixel-clock spacing is measured while host writes are in progress, which would reveal any write that delays the scan. The line and frame pulses are counted against the pixel-clock count across several frames.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    localparam int BUS_W    = 8;
    localparam int NIB_W    = 4;
    localparam int ADDR_W   = 2 * BUS_W;
    localparam int PH_W     = 5;
    localparam int SLOT_LEN = 19;
    localparam int WR_BASE  = 10;
    localparam int LP_PH    = 12;

    typedef enum logic [1:0] {
        SEL_Z   = 2'd0,
        SEL_ROW = 2'd1,
        SEL_COL = 2'd2,
        SEL_DAT = 2'd3
    } bus_sel_e;

    typedef struct packed {
        logic     ras_n;
        logic     cas_n;
        logic     we_n;
        logic     oe_n;
        bus_sel_e sel;
        logic     take;
        logic     xscl;
        logic     lp_slot;
    } phase_ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [NIB_W-1:0]  data;
    } nib_wr_t;

    // Slot phases 0..9 hold the scan read. Phases 10..18 hold an optional write.
    function automatic phase_ctl_t phase_decode(input logic [PH_W-1:0] ph,
                                                input logic            wr);
        phase_ctl_t c;
        c.ras_n   = 1'b1;
        c.cas_n   = 1'b1;
        c.we_n    = 1'b1;
        c.oe_n    = 1'b1;
        c.sel     = SEL_Z;
        c.take    = 1'b0;
        c.xscl    = 1'b0;
        c.lp_slot = (ph == PH_W'(LP_PH));
        case (ph)
            5'd0:  c.sel = SEL_ROW;
            5'd1:  begin c.ras_n = 1'b0; c.sel = SEL_ROW; end
            5'd2:  begin c.ras_n = 1'b0; c.sel = SEL_COL; end
            5'd3:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.sel = SEL_COL; end
            5'd4:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; end
            5'd5:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.oe_n = 1'b0; end
            5'd6:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.oe_n = 1'b0; c.take = 1'b1; end
            5'd7:  begin c.ras_n = 1'b0; c.cas_n = 1'b0; end
            5'd8:  begin c.ras_n = 1'b0; c.xscl = 1'b1; end
            5'd10: if (wr) c.sel = SEL_ROW;
            5'd11: if (wr) begin c.ras_n = 1'b0; c.sel = SEL_ROW; end
            5'd12: if (wr) begin c.ras_n = 1'b0; c.sel = SEL_COL; end
            5'd13: if (wr) begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.sel = SEL_COL; end
            5'd14: if (wr) begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.sel = SEL_DAT; end
            5'd15: if (wr) begin
                       c.ras_n = 1'b0; c.cas_n = 1'b0; c.we_n = 1'b0; c.sel = SEL_DAT;
                   end
            5'd16: if (wr) begin c.ras_n = 1'b0; c.cas_n = 1'b0; c.sel = SEL_DAT; end
            5'd17: if (wr) c.ras_n = 1'b0;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lcdscan_seq.sv
module lcdscan_seq
    import lcdscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  nib_wr_t           wr_item,
    input  logic [ADDR_W-1:0] scan_addr,
    output phase_ctl_t        ctl,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_drive,
    output logic              wr_done,
    output logic              slot_end
);

    logic [PH_W-1:0]   ph;
    logic              wr_act;
    nib_wr_t           wr_q;
    logic [ADDR_W-1:0] cur_addr;

    assign slot_end = (ph == PH_W'(SLOT_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= '0;
            wr_act <= 1'b0;
            wr_q   <= '0;
        end else begin
            ph <= slot_end ? '0 : ph + 1'b1;
            if (ph == PH_W'(WR_BASE - 1)) begin
                wr_act <= wr_req;
                wr_q   <= wr_item;
            end else if (slot_end) begin
                wr_act <= 1'b0;
            end
        end
    end

    assign ctl      = phase_decode(ph, wr_act);
    assign wr_done  = wr_act && slot_end;
    assign cur_addr = (ph >= PH_W'(WR_BASE)) ? wr_q.addr : scan_addr;

    always_comb begin
        case (ctl.sel)
            SEL_ROW: bus_out = cur_addr[BUS_W-1:0];
            SEL_COL: bus_out = cur_addr[ADDR_W-1:BUS_W];
            SEL_DAT: bus_out = {{(BUS_W - NIB_W){1'b0}}, wr_q.data};
            default: bus_out = '0;
        endcase
    end

    assign bus_drive = (ctl.sel != SEL_Z);

endmodule

// File: rtl/lcdscan_hostq.sv
module lcdscan_hostq
    import lcdscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic [ADDR_W-2:0] host_addr,
    input  logic [BUS_W-1:0]  host_data,
    output logic              host_ready,
    input  logic              wr_done,
    output logic              wr_req,
    output nib_wr_t           wr_item
);

    logic [1:0]        left;
    logic [ADDR_W-2:0] a_q;
    logic [BUS_W-1:0]  d_q;

    assign host_ready = (left == 2'd0);
    assign wr_req     = (left != 2'd0);

    // Two nibbles left: high half to the even address. One left: low half to the odd one.
    assign wr_item.addr = {a_q, (left == 2'd1)};
    assign wr_item.data = (left == 2'd1) ? d_q[NIB_W-1:0] : d_q[BUS_W-1:NIB_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= 2'd0;
            a_q  <= '0;
            d_q  <= '0;
        end else if (host_valid && host_ready) begin
            left <= 2'd2;
            a_q  <= host_addr;
            d_q  <= host_data;
        end else if (wr_done) begin
            left <= left - 2'd1;
        end
    end

endmodule

// File: rtl/lcdscan_raster.sv
module lcdscan_raster
    import lcdscan_pkg::*;
#(
    parameter int H_NIB   = 80,
    parameter int V_LINES = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              xscl_ph,
    input  logic              lp_ph,
    input  logic              slot_end,
    input  logic [NIB_W-1:0]  rd_nib,
    output logic [NIB_W-1:0]  lcd_data,
    output logic              lcd_xscl,
    output logic              lcd_lp,
    output logic              lcd_flm,
    output logic              lcd_tgl,
    output logic [ADDR_W-1:0] scan_addr
);

    localparam int COL_W  = (H_NIB > 1) ? $clog2(H_NIB) : 1;
    localparam int LINE_W = (V_LINES > 1) ? $clog2(V_LINES) : 1;

    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
    logic [NIB_W-1:0]  nib_q;
    logic              tgl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              last_col;
    logic              last_line;

    assign last_col  = (col == COL_W'(H_NIB - 1));
    assign last_line = (line == LINE_W'(V_LINES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            col    <= '0;
            line   <= '0;
            nib_q  <= '0;
            tgl_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            if (take) nib_q <= rd_nib;
            if (lcd_flm) tgl_q <= ~tgl_q;
            if (slot_end) begin
                if (last_col) begin
                    col <= '0;
                    if (last_line) begin
                        line   <= '0;
                        addr_q <= '0;
                    end else begin
                        line   <= line + 1'b1;
                        addr_q <= addr_q + 1'b1;
                    end
                end else begin
                    col    <= col + 1'b1;
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    assign lcd_data  = nib_q;
    assign lcd_xscl  = xscl_ph;
    assign lcd_lp    = lp_ph && last_col;
    assign lcd_flm   = lcd_lp && (line == '0);
    assign lcd_tgl   = tgl_q;
    assign scan_addr = addr_q;

endmodule

// File: rtl/lcdscan_top.sv
module lcdscan_top
    import lcdscan_pkg::*;
#(
    parameter int H_PIX   = 320,
    parameter int V_LINES = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [ADDR_W-2:0] host_addr,
    input  logic [BUS_W-1:0]  host_data,
    inout  wire  [BUS_W-1:0]  dram_ad,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [NIB_W-1:0]  lcd_data,
    output logic              lcd_xscl,
    output logic              lcd_lp,
    output logic              lcd_flm,
    output logic              lcd_tgl
);

    localparam int H_NIB = H_PIX / NIB_W;

    phase_ctl_t        ctl;
    logic [BUS_W-1:0]  bus_out;
    logic              bus_drive;
    logic              wr_done;
    logic              slot_end;
    logic              wr_req;
    nib_wr_t           wr_item;
    logic [ADDR_W-1:0] scan_addr;
    logic              unused_hi;

    lcdscan_hostq hostq_i (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_addr  (host_addr),
        .host_data  (host_data),
        .host_ready (host_ready),
        .wr_done    (wr_done),
        .wr_req     (wr_req),
        .wr_item    (wr_item)
    );

    lcdscan_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .wr_item   (wr_item),
        .scan_addr (scan_addr),
        .ctl       (ctl),
        .bus_out   (bus_out),
        .bus_drive (bus_drive),
        .wr_done   (wr_done),
        .slot_end  (slot_end)
    );

    lcdscan_raster #(
        .H_NIB   (H_NIB),
        .V_LINES (V_LINES)
    ) raster_i (
        .clk       (clk),
        .rst       (rst),
        .take      (ctl.take),
        .xscl_ph   (ctl.xscl),
        .lp_ph     (ctl.lp_slot),
        .slot_end  (slot_end),
        .rd_nib    (dram_ad[NIB_W-1:0]),
        .lcd_data  (lcd_data),
        .lcd_xscl  (lcd_xscl),
        .lcd_lp    (lcd_lp),
        .lcd_flm   (lcd_flm),
        .lcd_tgl   (lcd_tgl),
        .scan_addr (scan_addr)
    );

    // The bus is released in every phase where neither address nor data is sent.
    assign dram_ad    = bus_drive ? bus_out : {BUS_W{1'bz}};
    assign unused_hi  = ^dram_ad[BUS_W-1:NIB_W];

    assign dram_ras_n = ctl.ras_n;
    assign dram_cas_n = ctl.cas_n;
    assign dram_we_n  = ctl.we_n;
    assign dram_oe_n  = ctl.oe_n;

endmodule

// File: rtl/lcdscan_chk.sv
module lcdscan_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic xscl,
    input logic lp,
    input logic flm,
    input logic tgl,
    input logic host_valid,
    input logic host_ready
);

    // R3
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!ras_n && !cas_n));

    // R3
    oe_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> !cas_n);

    // R3
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> !ras_n);

    // R10
    we_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ras_n && !cas_n && oe_n));

    // R4
    xscl_width_chk: assert property (@(posedge clk) disable iff (rst)
        xscl |=> !xscl);

    // R6
    lp_width_chk: assert property (@(posedge clk) disable iff (rst)
        lp |=> !lp);

    // R7
    flm_with_lp_chk: assert property (@(posedge clk) disable iff (rst)
        flm |-> lp);

    // R8
    tgl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(flm) |-> $stable(tgl));

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> !host_ready);

endmodule

bind lcdscan_top lcdscan_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (dram_ras_n),
    .cas_n      (dram_cas_n),
    .we_n       (dram_we_n),
    .oe_n       (dram_oe_n),
    .xscl       (lcd_xscl),
    .lp         (lcd_lp),
    .flm        (lcd_flm),
    .tgl        (lcd_tgl),
    .host_valid (host_valid),
    .host_ready (host_ready)
);

// File: tb/lcdscan_top_tb_top.sv
`timescale 1ns/1ps
module lcdscan_top_tb_top;

    localparam int H_PIX  = 16;
    localparam int VL     = 3;
    localparam int H_NIB  = H_PIX / 4;
    localparam int FRAME  = H_NIB * VL;
    localparam int SLOT   = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    wire  [7:0]  dram_ad;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [3:0]  lcd_data;
    logic        lcd_xscl, lcd_lp, lcd_flm, lcd_tgl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lcdscan_top #(.H_PIX(H_PIX), .V_LINES(VL)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_ready (host_ready),
        .host_addr  (host_addr),
        .host_data  (host_data),
        .dram_ad    (dram_ad),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_oe_n  (dram_oe_n),
        .lcd_data   (lcd_data),
        .lcd_xscl   (lcd_xscl),
        .lcd_lp     (lcd_lp),
        .lcd_flm    (lcd_flm),
        .lcd_tgl    (lcd_tgl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural memory stub on the shared bus
    logic [7:0] st_row = '0;
    logic [7:0] st_col = '0;
    logic [3:0] st_q   = '0;
    logic [3:0] mem [int];

    always @(negedge dram_ras_n) st_row = dram_ad;
    always @(negedge dram_cas_n) st_col = dram_ad;

    always @(negedge dram_oe_n) begin
        st_q = mem.exists(int'({st_col, st_row})) ? mem[int'({st_col, st_row})] : 4'h0;
        if (!rst) chk(!dram_ras_n && !dram_cas_n, "R3 strobes low at OE fall",
                      {dram_ras_n, dram_cas_n}, 0);
    end

    assign dram_ad = (!dram_oe_n && !dram_cas_n) ? {4'h0, st_q} : 8'bz;

    always @(negedge dram_we_n) begin
        if (!rst) begin
            mem[int'({st_col, st_row})] = dram_ad[3:0];
            chk(dram_ad[7:4] == 4'h0, "R10 upper bus bits during write", dram_ad[7:4], 0);
        end
    end

    // Scoreboard monitor
    logic [3:0] exp_q[$];
    int  cyc = 0, prev_x = 0, xcount = 0, since_lp = 0, lp_count = 0;
    bit  have_prev = 0, flm_prev = 0, tgl_prev = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc++;
            if (lcd_xscl) begin
                int a;
                a = xcount % FRAME;
                chk(st_row == a[7:0], "R2 row address", st_row, a[7:0]);
                chk(st_col == a[15:8], "R2 column address", st_col, a[15:8]);
                if (have_prev) chk(cyc - prev_x == SLOT, "R5 pixel clock spacing", cyc - prev_x, SLOT);
                prev_x    = cyc;
                have_prev = 1;
                if (exp_q.size() > 0) begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    chk(lcd_data == e, "R4/R9 pixel word", lcd_data, e);
                end
                xcount++;
                since_lp++;
            end
            if (lcd_lp) begin
                chk(since_lp == H_NIB, "R6 words per line", since_lp, H_NIB);
                since_lp = 0;
                chk(lcd_flm == (lp_count % VL == 0), "R7 frame marker", lcd_flm, (lp_count % VL == 0));
                lp_count++;
            end
            if (flm_prev) chk(lcd_tgl != tgl_prev, "R8 toggle after frame marker", lcd_tgl, !tgl_prev);
            flm_prev = lcd_flm;
            tgl_prev = lcd_tgl;
        end
    end

    function automatic logic [3:0] pat(input int s, input int i);
        if (s == 0) return 4'((i * 7 + 3) & 15);
        return 4'(((i * 5 + 9) & 15) ^ 10);
    endfunction

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1;
        host_addr  = a[14:0];
        host_data  = d;
        @(negedge clk);
        host_valid = 1'b0;
        chk(!host_ready, "R9 ready low after accept", host_ready, 0);
    endtask

    task automatic wait_idle();
        while (!host_ready) @(negedge clk);
    endtask

    task automatic wait_frame_end();
        int k;
        do @(negedge clk); while (!lcd_flm);
        k = 0;
        while (k < VL - 1) begin
            @(negedge clk);
            if (lcd_lp) k++;
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic write_pattern(input int s);
        for (int b = 0; b < FRAME / 2; b++)
            host_write(b, {pat(s, 2 * b), pat(s, 2 * b + 1)});
        wait_idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!lcd_xscl && !lcd_lp && !lcd_flm && !lcd_tgl, "R1 panel outputs low",
            {lcd_xscl, lcd_lp, lcd_flm, lcd_tgl}, 0);
        chk(host_ready, "R1 host ready", host_ready, 1);
        rst = 1'b0;

        // Unwritten memory scans as zero
        wait_frame_end();
        for (int i = 0; i < FRAME; i++) exp_q.push_back(4'h0);
        drain();

        // Pattern A, then a full frame compare
        write_pattern(0);
        wait_frame_end();
        for (int i = 0; i < FRAME; i++) exp_q.push_back(pat(0, i));
        drain();

        // Pattern B written while the scan keeps running
        write_pattern(1);
        wait_frame_end();
        for (int i = 0; i < FRAME; i++) exp_q.push_back(pat(1, i));
        drain();

        // Single byte overwrite: high nibble to the even address (R9)
        host_write(3, 8'hC3);
        wait_idle();
        wait_frame_end();
        for (int i = 0; i < FRAME; i++) begin
            if (i == 6)      exp_q.push_back(4'hC);
            else if (i == 7) exp_q.push_back(4'h3);
            else             exp_q.push_back(pat(1, i));
        end
        drain();

        repeat (2 * SLOT) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 40000, 0);
            finish_run();
        end
    end

endmodule